// File: doc/BRIEF.md
# Bitmap glyph string writer

This block paints a zero-terminated string of character codes into a 64-pixel-wide framebuffer. A start pulse captures a pixel origin and a foreground and background colour. The block then pulls character codes one at a time over a valid/ready handshake. Each code is expanded from an internal 8-pixel by 11-row font into framebuffer writes, one write per pixel of the cell. Set font bits become foreground and clear bits become background, so the whole cell is overwritten.

Characters advance 8 pixels to the right. A caller that wants a second line starts a new string at the same x with y raised by 11, and a third line at y plus 22. Pixels that would land right of column 63 or below row 47 are dropped rather than wrapped. The display timing and the framebuffer memory sit outside this block. The framebuffer is driven through an address, a data word and a write-enable strobe.

Top module: `glyph_writer`

## Requirements
- R1: After reset, busy_o, done_o, chr_ready_o and fb_we_o are all 0 until a start pulse is accepted.
- R2: start_i is taken only while the block is idle (busy_o = 0 and done_o = 0). Taking it captures org_x_i, org_y_i, fg_i and bg_i, and later changes to these inputs or further start pulses during a string have no effect on the writes.
- R3: chr_ready_o is high only between glyphs, and never in the same cycle as a framebuffer write. A code is consumed on a clock edge where chr_valid_i and chr_ready_o are both high, and a held chr_valid_i is not consumed again while a glyph is being drawn.
- R4: Font row i (0..10) of code c is the byte at font offset a = c*11 + i. For codes 0x20 to 0x7E that byte is (a*29 + 7) mod 256. For all other codes every row is 0x00.
- R5: Each row byte is used from bit 7 down to bit 0. A 1 bit writes fg and a 0 bit writes bg, so all 88 pixels of an unclipped cell are written.
- R6: Pixel j of row i of the k-th character (k from 0) is written to address (x + j) + 8k + (y + i)*64. Writes come in order of character, then row 0..10, then bit position j 0..7.
- R7: A pixel whose column x + j + 8k exceeds 63 or whose row y + i exceeds 47 produces no write. The order of the remaining writes is unchanged.
- R8: Every write shows address and data for one cycle with fb_we_o low, then for one cycle with fb_we_o high and the same address and data. fb_we_o is never high in two consecutive cycles.
- R9: The zero code ends the string and is not drawn. done_o is high for exactly the one cycle after the edge that consumed it, with busy_o low, and the block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a string (taken when idle) |
| org_x_i | input | 6 | Pixel column of the first character's left edge |
| org_y_i | input | 6 | Pixel row of the characters' top edge |
| fg_i | input | 16 | Colour for set font bits |
| bg_i | input | 16 | Colour for clear font bits |
| chr_valid_i | input | 1 | A character code is offered |
| chr_code_i | input | 8 | Offered character code, zero ends the string |
| chr_ready_o | output | 1 | Block can take a code this cycle |
| fb_addr_o | output | 12 | Framebuffer write address |
| fb_data_o | output | 16 | Framebuffer write colour |
| fb_we_o | output | 1 | Framebuffer write strobe |
| busy_o | output | 1 | A string is in progress |
| done_o | output | 1 | One-cycle pulse after the terminator |

## Verification
The assertions check the following on every cycle:
- the write strobe shape of R8: a low setup cycle first, stable address and data, no back-to-back strobes;
- that no strobe reaches an address at or beyond row 48;
- that no strobe coincides with chr_ready_o;
- that the done pulse lasts a single cycle with busy_o low;
- that nothing is written while the block is idle.

The font contents, the MSB-first colour choice, the address arithmetic, the clipping at the right edge and the immunity to a mid-string start pulse are visible only in whole write sequences. The bench shows them by comparing every captured write against a sequence computed arithmetically, over a sweep of origins and strings.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_SETUP  = 3'd2,
    ST_STROBE = 3'd3,
    ST_DONE   = 3'd4
  } gw_state_t;
endpackage

// File: rtl/glyph_rst_sync.sv
module glyph_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/glyph_font_rom.sv
module glyph_font_rom #(
  parameter int FA_W  = 12,
  parameter int GW    = 8,
  parameter int GH    = 11,
  parameter int FIRST = 32,
  parameter int LAST  = 126
) (
  input  logic [FA_W-1:0] addr,
  output logic [GW-1:0]   row_bits
);
  localparam logic [FA_W-1:0] LO = FA_W'(FIRST * GH);
  localparam logic [FA_W-1:0] HI = FA_W'((LAST + 1) * GH);
  logic [31:0] mix;
  always_comb begin
    mix = 32'(addr) * 32'd29 + 32'd7;
    if (addr >= LO && addr < HI) row_bits = mix[GW-1:0];
    else                         row_bits = '0;
  end
endmodule

// File: rtl/glyph_pix_addr.sv
module glyph_pix_addr #(
  parameter int SUM_W = 16,
  parameter int COLS  = 64,
  parameter int ROWS  = 48,
  parameter int AW    = 12
) (
  input  logic [SUM_W-1:0] col_sum,
  input  logic [SUM_W-1:0] row_sum,
  output logic [AW-1:0]    addr,
  output logic             in_range
);
  logic [SUM_W-1:0] lin;
  always_comb begin
    lin      = col_sum + row_sum * SUM_W'(COLS);
    addr     = lin[AW-1:0];
    in_range = (col_sum < SUM_W'(COLS)) && (row_sum < SUM_W'(ROWS));
  end
endmodule

// File: rtl/glyph_writer.sv
module glyph_writer #(
  parameter int COLS   = 64,
  parameter int ROWS   = 48,
  parameter int AW     = 12,
  parameter int DW     = 16,
  parameter int CODE_W = 8,
  parameter int GW     = 8,
  parameter int GH     = 11,
  parameter int K_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [5:0]        org_x_i,
  input  logic [5:0]        org_y_i,
  input  logic [DW-1:0]     fg_i,
  input  logic [DW-1:0]     bg_i,
  input  logic              chr_valid_i,
  input  logic [CODE_W-1:0] chr_code_i,
  output logic              chr_ready_o,
  output logic [AW-1:0]     fb_addr_o,
  output logic [DW-1:0]     fb_data_o,
  output logic              fb_we_o,
  output logic              busy_o,
  output logic              done_o
);
  import glyph_pkg::*;

  localparam int IW    = $clog2(GH);
  localparam int JW    = $clog2(GW);
  localparam int FA_W  = CODE_W + IW;
  localparam int SUM_W = AW + 4;

  logic rst_s;
  gw_state_t state_q, state_n;
  logic [5:0]        ox_q, ox_n, oy_q, oy_n;
  logic [DW-1:0]     fg_q, fg_n, bg_q, bg_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [K_W-1:0]    k_q, k_n;
  logic [IW-1:0]     i_q, i_n;
  logic [JW-1:0]     j_q, j_n;
  logic [GW-1:0]     sh_q, sh_n;

  logic [FA_W-1:0]   rom_addr;
  logic [GW-1:0]     rom_bits;
  logic [SUM_W-1:0]  col_sum, row_sum;
  logic [AW-1:0]     pix_addr;
  logic              pix_ok;

  glyph_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  glyph_font_rom #(.FA_W(FA_W), .GW(GW), .GH(GH)) u_rom (
    .addr(rom_addr), .row_bits(rom_bits)
  );

  glyph_pix_addr #(.SUM_W(SUM_W), .COLS(COLS), .ROWS(ROWS), .AW(AW)) u_pa (
    .col_sum(col_sum), .row_sum(row_sum), .addr(pix_addr), .in_range(pix_ok)
  );

  // next row of the glyph is fetched while the last pixel of this row strobes
  always_comb begin
    if (state_q == ST_FETCH)
      rom_addr = FA_W'(chr_code_i) * FA_W'(GH);
    else
      rom_addr = FA_W'(code_q) * FA_W'(GH) + FA_W'(i_q) + FA_W'(1);
    col_sum = SUM_W'(ox_q) + SUM_W'(j_q) + SUM_W'(k_q) * SUM_W'(GW);
    row_sum = SUM_W'(oy_q) + SUM_W'(i_q);
  end

  always_comb begin
    state_n = state_q;
    ox_n = ox_q; oy_n = oy_q; fg_n = fg_q; bg_n = bg_q;
    code_n = code_q; k_n = k_q; i_n = i_q; j_n = j_q; sh_n = sh_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ox_n = org_x_i; oy_n = org_y_i; fg_n = fg_i; bg_n = bg_i;
        k_n = '0;
        state_n = ST_FETCH;
      end
      ST_FETCH: if (chr_valid_i) begin
        if (chr_code_i == '0) state_n = ST_DONE;
        else begin
          code_n = chr_code_i; i_n = '0; j_n = '0; sh_n = rom_bits;
          state_n = ST_SETUP;
        end
      end
      ST_SETUP: state_n = ST_STROBE;
      ST_STROBE: begin
        sh_n = sh_q << 1;
        state_n = ST_SETUP;
        if (j_q == JW'(GW - 1)) begin
          j_n = '0;
          if (i_q == IW'(GH - 1)) begin
            if (k_q != '1) k_n = k_q + K_W'(1);
            state_n = ST_FETCH;
          end else begin
            i_n = i_q + IW'(1);
            sh_n = rom_bits;
          end
        end else begin
          j_n = j_q + JW'(1);
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      ox_q <= '0; oy_q <= '0; fg_q <= '0; bg_q <= '0;
      code_q <= '0; k_q <= '0; i_q <= '0; j_q <= '0; sh_q <= '0;
    end else begin
      state_q <= state_n;
      ox_q <= ox_n; oy_q <= oy_n; fg_q <= fg_n; bg_q <= bg_n;
      code_q <= code_n; k_q <= k_n; i_q <= i_n; j_q <= j_n; sh_q <= sh_n;
    end
  end

  logic pix_phase;
  assign pix_phase   = (state_q == ST_SETUP) || (state_q == ST_STROBE);
  assign fb_addr_o   = pix_phase ? pix_addr : '0;
  assign fb_data_o   = pix_phase ? (sh_q[GW-1] ? fg_q : bg_q) : '0;
  assign fb_we_o     = (state_q == ST_STROBE) && pix_ok;
  assign chr_ready_o = (state_q == ST_FETCH);
  assign busy_o      = (state_q == ST_FETCH) || pix_phase;
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/glyph_writer_chk.sv
module glyph_writer_chk #(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int COLS = 64,
  parameter int ROWS = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fb_addr_o,
  input logic [DW-1:0] fb_data_o,
  input logic          fb_we_o,
  input logic          chr_ready_o,
  input logic          busy_o,
  input logic          done_o
);
  a_r8_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we_o |-> !$past(fb_we_o));
  a_r8_stable_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we_o |-> ($stable(fb_addr_o) && $stable(fb_data_o)));
  a_r7_row_limit: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we_o |-> (fb_addr_o < AW'(ROWS * COLS)));
  a_r3_no_ready_write: assert property (@(posedge clk) disable iff (!rst_n)
    chr_ready_o |-> !fb_we_o);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!fb_we_o && !chr_ready_o));
endmodule

bind glyph_writer glyph_writer_chk #(.AW(AW), .DW(DW), .COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_addr_o(fb_addr_o), .fb_data_o(fb_data_o),
  .fb_we_o(fb_we_o), .chr_ready_o(chr_ready_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/glyph_writer_test.sv
module glyph_writer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [5:0] org_x_i = '0, org_y_i = '0;
  logic [15:0] fg_i = '0, bg_i = '0;
  logic chr_valid_i = 1'b0;
  logic [7:0] chr_code_i = '0;
  logic chr_ready_o, fb_we_o, busy_o, done_o;
  logic [11:0] fb_addr_o;
  logic [15:0] fb_data_o;

  int checks = 0, errors = 0;
  int rec_cnt = 0;
  logic [11:0] rec_addr [0:4095];
  logic [15:0] rec_data [0:4095];
  logic [7:0]  str [0:7];

  always #10 clk = ~clk;

  glyph_writer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .org_x_i(org_x_i), .org_y_i(org_y_i),
    .fg_i(fg_i), .bg_i(bg_i), .chr_valid_i(chr_valid_i), .chr_code_i(chr_code_i),
    .chr_ready_o(chr_ready_o), .fb_addr_o(fb_addr_o), .fb_data_o(fb_data_o),
    .fb_we_o(fb_we_o), .busy_o(busy_o), .done_o(done_o)
  );

  always @(negedge clk) begin
    if (fb_we_o && rec_cnt < 4096) begin
      rec_addr[rec_cnt] = fb_addr_o;
      rec_data[rec_cnt] = fb_data_o;
      rec_cnt = rec_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int font_byte(input int a);
    if (a >= 32 * 11 && a < 127 * 11) return (a * 29 + 7) % 256;
    return 0;
  endfunction

  task automatic send(input logic [7:0] c);
    chr_valid_i = 1'b1;
    chr_code_i = c;
    while (!chr_ready_o) @(negedge clk);
    @(negedge clk);
    chr_valid_i = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R7 R9: run a string and compare every write
  task automatic run(input int x, input int y, input logic [15:0] fg, input logic [15:0] bg,
                     input int n, input bit poke);
    int e, bad_i, ba, bd, ea, ed;
    rec_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; org_x_i = 6'(x); org_y_i = 6'(y); fg_i = fg; bg_i = bg;
    @(negedge clk);
    start_i = 1'b0;
    for (int idx = 0; idx < n; idx++) begin
      send(str[idx]);
      if (poke && idx == 0) begin
        start_i = 1'b1; org_x_i = 6'(x + 5); org_y_i = 6'(y + 3); fg_i = ~fg; bg_i = ~bg;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    send(8'h00);
    chk(done_o === 1'b1 && busy_o === 1'b0, "R9 done after terminator", int'(done_o), 1);
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R9 done single cycle", int'(done_o), 0);
    e = 0; bad_i = -1; ba = 0; bd = 0; ea = 0; ed = 0;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 11; i++)
        for (int j = 0; j < 8; j++) begin
          int b, col, row, a;
          logic [15:0] d;
          b = font_byte(str[k] * 11 + i);
          col = x + j + 8 * k;
          row = y + i;
          if (col < 64 && row < 48) begin
            a = col + row * 64;
            d = ((b >> (7 - j)) & 1) != 0 ? fg : bg;
            if (bad_i < 0 && (e >= rec_cnt || rec_addr[e] !== 12'(a) || rec_data[e] !== d)) begin
              bad_i = e; ea = a; ed = int'(d);
              if (e < rec_cnt) begin ba = int'(rec_addr[e]); bd = int'(rec_data[e]); end
            end
            e++;
          end
        end
    chk(rec_cnt == e, "R7 write count", rec_cnt, e);
    chk(bad_i < 0, "R6 R5 R4 write sequence addr", ba, ea);
    if (bad_i >= 0) $display("  mismatch at write %0d data %0h exp %0h", bad_i, bd, ed);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy_o === 0 && done_o === 0 && chr_ready_o === 0 && fb_we_o === 0,
        "R1 reset state", int'({busy_o, done_o, chr_ready_o, fb_we_o}), 0);
    // R5 R6 basic two characters at origin
    str[0] = 8'h41; str[1] = 8'h42;
    run(0, 0, 16'hFFFF, 16'h0000, 2, 0);
    // R6 second text line at y+11
    str[0] = 8'h7E; str[1] = 8'h20; str[2] = 8'h5A;
    run(4, 11, 16'h238F, 16'h1111, 3, 0);
    // R7 clip right edge and bottom edge
    str[0] = 8'h33; str[1] = 8'h34;
    run(60, 40, 16'hABCD, 16'h0F0F, 2, 0);
    // R4 code outside font subset draws background only
    str[0] = 8'h01; str[1] = 8'h7F;
    run(8, 8, 16'hFFFF, 16'h5555, 2, 0);
    // R9 empty string: terminator only, no writes
    run(10, 10, 16'hFFFF, 16'h0000, 0, 0);
    // R2 R3 start pulse mid-string ignored
    str[0] = 8'h48; str[1] = 8'h69;
    run(16, 20, 16'hF800, 16'h07E0, 2, 1);
    // R7 long string running off the right edge
    for (int q = 0; q < 8; q++) str[q] = 8'(8'h50 + q);
    run(30, 2, 16'h1234, 16'h4321, 8, 0);
    // R6 R7 sweep of origins
    for (int xi = 0; xi < 64; xi += 7)
      for (int yv = 0; yv < 4; yv++) begin
        str[0] = 8'(8'h41 + xi % 26); str[1] = 8'(8'h30 + yv);
        run(xi, yv * 13, 16'(xi * 1000 + yv), 16'(~(xi * 77)), 2, 0);
      end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule